// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a fast source clock into a train of single-cycle enable pulses whose long-run rate is the source rate divided by N + A/B + 1. N is the integer part; A/B is a fraction that is spread across periods. Most periods last N + 1 source cycles. Some periods last one cycle longer, so the average period comes out right. Logic in the slower domain uses the enable pulse as a clock qualifier.

Software programs N, A, B, a gate bit and a stored source-select value through a small word-wide register port with combinational readback. New values are used from the next period boundary. The block refuses writes that would break the fraction: the numerator must stay below the denominator, and the denominator must not be zero. Turning the gate off stops the pulses at once and resets the count and the fraction. The source select is only stored and reported. The block does no clock switching.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, readback gives N = 15, A = 0, B = 1, gate = 0 and select = 0, and `clk_en_o` stays low.
- R2: While the gate is 0, `clk_en_o` stays low and the period count and fraction are cleared. After a write that sets the gate, `clk_en_o` is low in the cycle after that write edge and high in the cycle after the next edge.
- R3: With A = 0, consecutive pulses are exactly N + 1 source cycles apart.
- R4: The pulse numbered k (k = 0 is the first pulse after the gate turns on or after a fraction restart) is followed by a gap of N + 1 + floor((k+1)·A/B) − floor(k·A/B) cycles.
- R5: Any B consecutive periods together last B·(N+1) + A source cycles.
- R6: A write to A (address 1) is accepted only if the whole data word is below the current B. A write to B (address 2) is accepted only if it is nonzero, above the current A and no larger than 2^F_W − 1. A write to N (address 0) is accepted only if it fits in N_W bits. A rejected write leaves its field unchanged.
- R7: A control write (address 3) uses bit SRC_W as the gate (bit 2 by default) and bits SRC_W−1:0 as the select. Select codes 0, 1 and 2 are accepted. Code 3 leaves the select unchanged, but the gate bit is still applied. A control write with any bit set above the gate bit is ignored completely. `src_sel_o` shows the stored select.
- R8: A register write takes effect at the next period boundary. The period already under way keeps its length. An accepted write to A or B restarts the fraction sequence (k = 0) at that boundary.
- R9: Readback on `rdata_o` is combinational from `addr_i`. Address 0 returns N, 1 returns A, 2 returns B, and 3 returns {gate, select}. Unused upper bits read 0.
- R10: With N = 0 and A = 0, `clk_en_o` is high on every cycle while the gate is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and readback |
| wdata_i | input | D_W (8) | Write data |
| rdata_o | output | D_W (8) | Readback of the addressed register |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| src_sel_o | output | SRC_W (2) | Stored source-select code |

## Verification
The hardest case to reach from the ports is a fraction restart that lands in the middle of a running sequence. The new numerator must start at the next boundary and not at the write, and the period already under way must keep its old length. The bench hits this by waiting for a pulse, then writing A in the very next cycle, so the write falls inside a known period. It then compares the following gaps against the restarted sequence, which differs from the one that would continue unchanged. Randomized N, A and B settings, with A kept below B, are checked gap by gap and over full denominator windows. Directed cases cover the largest integer part and the divide-by-one setting.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [1:0] {
      FCD_REG_INT  = 2'd0,
      FCD_REG_NUM  = 2'd1,
      FCD_REG_DEN  = 2'd2,
      FCD_REG_CTL  = 2'd3
   } fcd_reg_e;

   function automatic int fcd_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
   import fcd_pkg::*;
#(
   parameter int N_W       = 8,
   parameter int F_W       = 6,
   parameter int D_W       = 8,
   parameter int SRC_CODES = 3,
   parameter int SRC_W     = 2,
   parameter int N_RST     = 15,
   parameter int A_RST     = 0,
   parameter int B_RST     = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [D_W-1:0]   wdata_i,
   output logic [D_W-1:0]   rdata_o,
   output logic [N_W-1:0]   int_o,
   output logic [F_W-1:0]   num_o,
   output logic [F_W-1:0]   den_o,
   output logic             gate_o,
   output logic [SRC_W-1:0] src_o,
   output logic             frac_chg_o
);

   localparam logic [D_W-1:0] INT_MAX = D_W'((1 << N_W) - 1);
   localparam logic [D_W-1:0] DEN_MAX = D_W'((1 << F_W) - 1);

   logic             wr_int, wr_num, wr_den, wr_ctl;
   logic             int_ok, num_ok, den_ok, src_ok, ctl_ok;
   logic [SRC_W-1:0] wsrc;
   logic             wgate;

   assign wr_int = wr_en_i && (addr_i == FCD_REG_INT);
   assign wr_num = wr_en_i && (addr_i == FCD_REG_NUM);
   assign wr_den = wr_en_i && (addr_i == FCD_REG_DEN);
   assign wr_ctl = wr_en_i && (addr_i == FCD_REG_CTL);

   assign int_ok = (wdata_i <= INT_MAX);
   assign num_ok = (wdata_i < D_W'(den_o));
   assign den_ok = (wdata_i != '0) && (wdata_i > D_W'(num_o)) && (wdata_i <= DEN_MAX);

   assign wsrc  = wdata_i[SRC_W-1:0];
   assign wgate = wdata_i[SRC_W];

   // Legal select codes: all codes when the count fills the field, else a compare.
   if ((1 << SRC_W) == SRC_CODES) begin : g_src_full
      assign src_ok = 1'b1;
   end else begin : g_src_part
      assign src_ok = (wsrc < SRC_W'(SRC_CODES));
   end

   // Reserved control bits above the gate must be zero for the write to land.
   if (D_W > SRC_W + 1) begin : g_ctl_rsvd
      assign ctl_ok = (wdata_i[D_W-1:SRC_W+1] == '0);
   end else begin : g_ctl_full
      assign ctl_ok = 1'b1;
   end

   assign frac_chg_o = (wr_num && num_ok) || (wr_den && den_ok);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         int_o  <= N_W'(N_RST);
         num_o  <= F_W'(A_RST);
         den_o  <= F_W'(B_RST);
         gate_o <= 1'b0;
         src_o  <= '0;
      end else begin
         if (wr_int && int_ok) int_o <= wdata_i[N_W-1:0];
         if (wr_num && num_ok) num_o <= wdata_i[F_W-1:0];
         if (wr_den && den_ok) den_o <= wdata_i[F_W-1:0];
         if (wr_ctl && ctl_ok) begin
            gate_o <= wgate;
            if (src_ok) src_o <= wsrc;
         end
      end
   end

   always_comb begin
      unique case (fcd_reg_e'(addr_i))
         FCD_REG_INT: rdata_o = D_W'(int_o);
         FCD_REG_NUM: rdata_o = D_W'(num_o);
         FCD_REG_DEN: rdata_o = D_W'(den_o);
         FCD_REG_CTL: rdata_o = D_W'({gate_o, src_o});
         default:     rdata_o = '0;
      endcase
   end

   AST_NUM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni) num_o < den_o); // R6
   AST_DEN_NONZERO:   assert property (@(posedge clk_i) disable iff (!rst_ni) den_o != '0); // R6
   AST_SRC_LEGAL:     assert property (@(posedge clk_i) disable iff (!rst_ni) src_o < SRC_W'(SRC_CODES) || (1 << SRC_W) == SRC_CODES); // R7
   AST_REJECT_HOLDS:  assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_den && !den_ok) |=> $stable(den_o)); // R6

endmodule

// File: rtl/fcd_frac.sv
module fcd_frac #(
   parameter int F_W = 6
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clr_i,
   input  logic           step_i,
   input  logic           chg_i,
   input  logic [F_W-1:0] num_i,
   input  logic [F_W-1:0] den_i,
   output logic           carry_o
);

   logic [F_W-1:0] acc_q;
   logic           pend_q;
   logic [F_W-1:0] base;
   logic [F_W:0]   sum;
   logic [F_W:0]   diff;

   assign base    = pend_q ? '0 : acc_q;
   assign sum     = {1'b0, base} + {1'b0, num_i};
   assign diff    = sum - {1'b0, den_i};
   assign carry_o = (sum >= {1'b0, den_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= chg_i || (pend_q && !step_i);
         if (clr_i)       acc_q <= '0;
         else if (step_i) acc_q <= carry_o ? diff[F_W-1:0] : sum[F_W-1:0];
      end
   end

   AST_ACC_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni) !pend_q |-> acc_q < den_i); // R4

endmodule

// File: rtl/fcd_count.sv
module fcd_count #(
   parameter int N_W = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           run_i,
   input  logic [N_W-1:0] int_i,
   input  logic           stretch_i,
   output logic           edge_o,
   output logic           tick_o
);

   localparam int C_W = N_W + 1;

   logic [C_W-1:0] cnt_q;

   assign edge_o = run_i && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q  <= {1'b0, int_i} + C_W'(stretch_i);
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
         tick_o <= 1'b0;
      end
   end

   AST_QUIET_WHEN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) !run_i |=> !tick_o); // R2
   AST_LOAD_BOUND:       assert property (@(posedge clk_i) disable iff (!rst_ni) tick_o |-> cnt_q <= C_W'((1 << N_W))); // R3

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import fcd_pkg::*;
#(
   parameter  int N_W       = 8,
   parameter  int F_W       = 6,
   parameter  int SRC_CODES = 3,
   parameter  int N_RST     = 15,
   parameter  int A_RST     = 0,
   parameter  int B_RST     = 1,
   localparam int SRC_W     = $clog2(SRC_CODES),
   localparam int D_W       = fcd_max(fcd_max(N_W, F_W), SRC_W + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [D_W-1:0]   wdata_i,
   output logic [D_W-1:0]   rdata_o,
   output logic             clk_en_o,
   output logic [SRC_W-1:0] src_sel_o
);

   if (SRC_CODES < 2) begin : g_bad_src
      $error("SRC_CODES must be at least 2");
   end
   if (B_RST < 1 || B_RST >= (1 << F_W)) begin : g_bad_den
      $error("B_RST out of range");
   end
   if (A_RST < 0 || A_RST >= B_RST) begin : g_bad_num
      $error("A_RST must lie below B_RST");
   end
   if (N_RST < 0 || N_RST >= (1 << N_W)) begin : g_bad_int
      $error("N_RST does not fit N_W");
   end

   logic [N_W-1:0] int_v;
   logic [F_W-1:0] num_v, den_v;
   logic           gate_v, frac_chg, boundary, stretch;

   fcd_regs #(
      .N_W(N_W), .F_W(F_W), .D_W(D_W), .SRC_CODES(SRC_CODES), .SRC_W(SRC_W),
      .N_RST(N_RST), .A_RST(A_RST), .B_RST(B_RST)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .int_o      (int_v),
      .num_o      (num_v),
      .den_o      (den_v),
      .gate_o     (gate_v),
      .src_o      (src_sel_o),
      .frac_chg_o (frac_chg)
   );

   fcd_frac #(.F_W(F_W)) u_frac (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (!gate_v),
      .step_i  (boundary),
      .chg_i   (frac_chg),
      .num_i   (num_v),
      .den_i   (den_v),
      .carry_o (stretch)
   );

   fcd_count #(.N_W(N_W)) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (gate_v),
      .int_i     (int_v),
      .stretch_i (stretch),
      .edge_o    (boundary),
      .tick_o    (clk_en_o)
   );

endmodule

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       clk_en;
   logic [1:0] src_sel;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   frac_clk_div i_frac_clk_div (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .clk_en_o(clk_en), .src_sel_o(src_sel)
   );

   function automatic int gap_exp(input int n, input int a, input int b, input int k);
      return n + 1 + ((k + 1) * a) / b - (k * a) / b;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Write issued at the current negedge (caller already sits on one).
   task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic next_gap(output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!clk_en && g < 5000);
   endtask

   // Gate off, load fields, gate on; returns at the negedge showing the first pulse.
   task automatic start(input int n, input int a, input int b, input string req);
      int v;
      wr(2'd3, 8'd0);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'(b));
      wr(2'd1, 8'(a));
      wr(2'd0, 8'(n));
      wr(2'd3, 8'h04);
      check({req, " no pulse right after gate write"}, int'(clk_en), 0);
      @(negedge clk);
      check({req, " first pulse one edge later"}, int'(clk_en), 1);
      rd(2'd2, v);
      check({req, " B readback"}, v, b);
   endtask

   task automatic run_cfg(input int n, input int a, input int b, input int cnt);
      int g, tot;
      start(n, a, b, "R2");
      tot = 0;
      for (int k = 0; k < cnt; k++) begin
         next_gap(g);
         check($sformatf("R4 gap k=%0d n=%0d a=%0d b=%0d", k, n, a, b), g, gap_exp(n, a, b, k));
         if (k < b) tot += g;
      end
      if (cnt >= b) check("R5 window sum", tot, b * (n + 1) + a);
   endtask

   initial begin
      int v, g;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); check("R1 N reset", v, 15);
      rd(2'd1, v); check("R1 A reset", v, 0);
      rd(2'd2, v); check("R1 B reset", v, 1);
      rd(2'd3, v); check("R1 ctl reset", v, 0);
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(clk_en); end
         check("R1 no pulses after reset", seen, 0);
      end

      // R3 default ratio, gate on only
      wr(2'd3, 8'h04);
      @(negedge clk);
      check("R2 first pulse", int'(clk_en), 1);
      for (int k = 0; k < 4; k++) begin next_gap(g); check("R3 default gap", g, 16); end

      // R2 gate off keeps output quiet
      wr(2'd3, 8'h00);
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(clk_en); end
         check("R2 quiet while gated", seen, 0);
      end

      // R10 divide by one
      start(0, 0, 1, "R10");
      begin
         int seen = 0;
         for (int i = 0; i < 12; i++) begin @(negedge clk); seen += int'(clk_en); end
         check("R10 pulse every cycle", seen, 12);
      end

      // R4/R5 directed fractions and the widest integer part
      run_cfg(2, 2, 3, 7);
      run_cfg(1, 1, 3, 6);
      run_cfg(255, 1, 2, 3);
      run_cfg(3, 62, 63, 64);

      // R4/R5 random fractions
      for (int t = 0; t < 10; t++) begin
         int n = int'($urandom % 25);
         int b = 1 + int'($urandom % 63);
         int a = int'($urandom % b);
         run_cfg(n, a, b, b + 2);
      end

      // R8 N change mid-period: current period keeps old length
      start(3, 0, 1, "R8");
      wr_now(2'd0, 8'd7);
      next_gap(g); check("R8 running period unchanged", g + 1, 4);
      next_gap(g); check("R8 new N at boundary", g, 8);
      next_gap(g); check("R8 new N steady", g, 8);

      // R8 fraction restart: old sequence 2,2,3 then restart with A=2 -> 2,3,3
      start(1, 1, 3, "R8");
      wr_now(2'd1, 8'd2);
      next_gap(g); check("R8 period under way", g + 1, 2);
      for (int k = 0; k < 3; k++) begin
         next_gap(g); check($sformatf("R8 restart gap k=%0d", k), g, gap_exp(1, 2, 3, k));
      end

      // R6 rejected field writes (current A=2, B=3)
      wr(2'd1, 8'd3);   rd(2'd1, v); check("R6 A equal B rejected", v, 2);
      wr(2'd1, 8'd200); rd(2'd1, v); check("R6 A large rejected", v, 2);
      wr(2'd2, 8'd2);   rd(2'd2, v); check("R6 B not above A rejected", v, 3);
      wr(2'd2, 8'd0);   rd(2'd2, v); check("R6 B zero rejected", v, 3);
      wr(2'd2, 8'd64);  rd(2'd2, v); check("R6 B too wide rejected", v, 3);
      wr(2'd2, 8'd63);  rd(2'd2, v); check("R6 B accepted", v, 63);
      wr(2'd1, 8'd62);  rd(2'd1, v); check("R6 A accepted", v, 62);
      wr(2'd0, 8'd255); rd(2'd0, v); check("R9 N readback", v, 255);

      // R7 select handling
      wr(2'd3, 8'h02); rd(2'd3, v); check("R7 select 2 gate 0", v, 2);
      check("R7 select port", int'(src_sel), 2);
      wr(2'd3, 8'h07); rd(2'd3, v); check("R7 code 3 ignored gate applied", v, 6);
      wr(2'd3, 8'h09); rd(2'd3, v); check("R7 reserved bit ignores write", v, 6);
      wr(2'd3, 8'h01); rd(2'd3, v); check("R7 select 1", v, 1);
      check("R7 select port 1", int'(src_sel), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc = 0;
      while (cyc < 190000) begin @(posedge clk); cyc++; end
      errors++;
      checks++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule